// File: doc/BRIEF.md
# Core Standby Clock Controller

This block puts the processor core into a low-power standby state and takes it out again. The core clock enable is held low for as long as needed. The peripheral clock enable stays high throughout, so peripherals and DMA-capable memory units keep working while the core sleeps. Software starts standby by writing a control word with the await flag (bit 15) set, for example 0x8000.

After the write, the controller waits for exactly one more instruction-issue strobe from the core. Once that instruction has issued, it stops the core clock. A pending interrupt or trap request then clears the await flag in hardware and turns the core clock back on. A request that arrives while the controller is still waiting for the last instruction cancels standby. The other fifteen bits of the control word are ordinary storage and read back exactly as written.

Top module: `core_standby_ctl`

## Requirements
- R1: While reset is active and in the first cycle after it, core_clk_en is 1 and ctl_rdata is 0x0000, so the await flag (bit 15) reads 0.
- R2: A write with bit 15 set, made while the core runs, makes bit 15 of ctl_rdata read 1 from the next cycle on, and core_clk_en stays 1.
- R3: With the flag armed, core_clk_en stays 1 until an issue strobe arrives. In the cycle after that strobe it drops to 0.
- R4: Once core_clk_en is 0, it stays 0 for as many cycles as wake_req stays low, with no upper limit.
- R5: wake_req high while the core is stopped makes core_clk_en 1 and clears bit 15 of ctl_rdata in the next cycle.
- R6: wake_req high while the flag is armed but before the issue strobe cancels standby. In the next cycle bit 15 reads 0, and a later issue strobe does not stop the core.
- R7: A write with bit 15 clear while the flag is armed cancels standby in the same way, unless an issue strobe arrives in that same cycle. In that case the strobe wins and the core stops.
- R8: Every write stores bits 14:0, in any state, and they read back unchanged from the next cycle on. A write made while the core is stopped does not change bit 15.
- R9: periph_clk_en is 1 in every cycle after reset, including every cycle in which core_clk_en is 0.
- R10: While the flag is clear, neither issue strobes nor writes with bit 15 clear ever lower core_clk_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data; bit 15 is the await flag |
| ctl_rdata | output | 16 | Control word read data; bit 15 shows the current await state |
| issue | input | 1 | Pulses once for each instruction the core issues |
| wake_req | input | 1 | An interrupt or trap request is pending |
| core_clk_en | output | 1 | Core clock enable; 0 while in standby |
| periph_clk_en | output | 1 | Peripheral clock enable; never lowered by standby |

## Verification
The embedded properties check these on every cycle:
- the single-cycle handoffs: arming on a write with bit 15 set, stopping only on the cycle after an armed issue strobe, and resuming with the flag cleared on the cycle after a wake request;
- that a stopped core stays stopped until a request arrives;
- that the stored low bits follow each write.

Some behaviours show only over whole scenarios in the bench:
- an arbitrarily long sleep;
- cancellation by a request or by a clearing write before the last instruction issues;
- the priority between a clearing write and a simultaneous issue strobe;
- a write to the low bits during sleep;
- the peripheral enable staying high throughout.

A behavioural reference model runs under random traffic to cover the orderings that the directed steps do not reach.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int STBY_DATA_W    = 16;
    localparam int STBY_AWAIT_BIT = 15;

    typedef enum logic [1:0] {
        STB_RUN   = 2'd0,
        STB_ARMED = 2'd1,
        STB_SLEEP = 2'd2
    } stby_state_e;

    typedef struct packed {
        logic wr;
        logic wbit;
        logic iss;
        logic wake;
    } stby_evt_t;

    // Wake beats issue, and issue beats a clearing write.
    function automatic stby_state_e stby_next(stby_state_e cur, stby_evt_t ev);
        stby_state_e nxt;
        nxt = cur;
        case (cur)
            STB_RUN:   if (ev.wr && ev.wbit) nxt = STB_ARMED;
            STB_ARMED: begin
                if (ev.wake)                   nxt = STB_RUN;
                else if (ev.iss)               nxt = STB_SLEEP;
                else if (ev.wr && !ev.wbit)    nxt = STB_RUN;
            end
            STB_SLEEP: if (ev.wake) nxt = STB_RUN;
            default:   nxt = STB_RUN;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stby_evt_t ev,
    output logic      await_flag,
    output logic      core_en
);

    stby_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= STB_RUN;
        else     state_q <= stby_next(state_q, ev);
    end

    assign await_flag = (state_q != STB_RUN);
    assign core_en    = (state_q != STB_SLEEP);

    p_arm_on_write_r2: assert property (@(posedge clk) disable iff (rst)
        (!await_flag && ev.wr && ev.wbit) |=> (await_flag && core_en));

    p_stop_after_issue_r3: assert property (@(posedge clk) disable iff (rst)
        (core_en && !(await_flag && ev.iss && !ev.wake)) |=> core_en);

    p_hold_sleep_r4: assert property (@(posedge clk) disable iff (rst)
        (!core_en && !ev.wake) |=> !core_en);

    p_wake_resume_r5: assert property (@(posedge clk) disable iff (rst)
        (!core_en && ev.wake) |=> (core_en && !await_flag));

    p_armed_cancel_r6: assert property (@(posedge clk) disable iff (rst)
        (core_en && await_flag && ev.wake) |=> (core_en && !await_flag));

endmodule

// File: rtl/stby_reg.sv
module stby_reg #(
    parameter int DATA_W    = 16,
    parameter int AWAIT_BIT = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              await_flag,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << AWAIT_BIT);

    logic [DATA_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst)     store_q <= '0;
        else if (we) store_q <= wdata & KEEP_MASK;
    end

    always_comb begin
        rdata            = store_q;
        rdata[AWAIT_BIT] = await_flag;
    end

    p_low_bits_kept_r8: assert property (@(posedge clk) disable iff (rst)
        we |=> ((rdata & KEEP_MASK) == ($past(wdata) & KEEP_MASK)));

endmodule

// File: rtl/core_standby_ctl.sv
module core_standby_ctl
    import stby_pkg::*;
#(
    parameter int DATA_W    = STBY_DATA_W,
    parameter int AWAIT_BIT = STBY_AWAIT_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    input  logic              issue,
    input  logic              wake_req,
    output logic              core_clk_en,
    output logic              periph_clk_en
);

    stby_evt_t ev;
    logic      await_flag;

    always_comb begin
        ev.wr   = ctl_we;
        ev.wbit = ctl_wdata[AWAIT_BIT];
        ev.iss  = issue;
        ev.wake = wake_req;
    end

    stby_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .await_flag (await_flag),
        .core_en    (core_clk_en)
    );

    stby_reg #(
        .DATA_W    (DATA_W),
        .AWAIT_BIT (AWAIT_BIT)
    ) u_reg (
        .clk        (clk),
        .rst        (rst),
        .we         (ctl_we),
        .wdata      (ctl_wdata),
        .await_flag (await_flag),
        .rdata      (ctl_rdata)
    );

    // Standby never touches the peripheral domain.
    assign periph_clk_en = 1'b1;

endmodule

// File: tb/test_core_standby_ctl.sv
module test_core_standby_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        issue = 1'b0;
    logic        wake_req = 1'b0;
    logic        core_clk_en;
    logic        periph_clk_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    core_standby_ctl i_core_standby_ctl (
        .clk           (clk),
        .rst           (rst),
        .ctl_we        (ctl_we),
        .ctl_wdata     (ctl_wdata),
        .ctl_rdata     (ctl_rdata),
        .issue         (issue),
        .wake_req      (wake_req),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en)
    );

    // Behavioural reference: 0 = running, 1 = waiting for last issue, 2 = stopped
    int          m_mode = 0;
    logic [14:0] m_low  = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= 0;
            m_low  <= '0;
        end else begin
            if (ctl_we) m_low <= ctl_wdata[14:0];
            if (m_mode == 0) begin
                if (ctl_we && ctl_wdata[15]) m_mode <= 1;
            end else if (m_mode == 1) begin
                if (wake_req)                      m_mode <= 0;
                else if (issue)                    m_mode <= 2;
                else if (ctl_we && !ctl_wdata[15]) m_mode <= 0;
            end else begin
                if (wake_req) m_mode <= 0;
            end
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3", {15'd0, core_clk_en}, {15'd0, m_mode != 2});
            check("R8", ctl_rdata, {m_mode != 0, m_low});
            check("R9", {15'd0, periph_clk_en}, 16'd1);
        end
    end

    // Apply inputs just after a falling edge; outputs settle by the next one
    task automatic step(logic we, logic [15:0] wd, logic iss, logic wk);
        ctl_we    = we;
        ctl_wdata = wd;
        issue     = iss;
        wake_req  = wk;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    initial begin
        #1000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", ctl_rdata, 16'h0000);
        check("R1", {15'd0, core_clk_en}, 16'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R1", ctl_rdata, 16'h0000);

        // R8 / R10: plain writes and issue strobes while running
        step(1'b1, 16'h1234, 1'b0, 1'b0);
        check("R8", ctl_rdata, 16'h1234);
        step(1'b0, 16'h0, 1'b1, 1'b0);
        step(1'b1, 16'h0055, 1'b1, 1'b0);
        check("R10", {15'd0, core_clk_en}, 16'd1);
        check("R8", ctl_rdata, 16'h0055);

        // R2 / R3 / R4 / R5: full standby cycle
        step(1'b1, 16'h8005, 1'b0, 1'b0);
        check("R2", ctl_rdata, 16'h8005);
        check("R2", {15'd0, core_clk_en}, 16'd1);
        idle(3);
        check("R3", {15'd0, core_clk_en}, 16'd1);
        step(1'b0, 16'h0, 1'b1, 1'b0);
        check("R3", {15'd0, core_clk_en}, 16'd0);
        idle(60);
        check("R4", {15'd0, core_clk_en}, 16'd0);
        step(1'b1, 16'h0007, 1'b0, 1'b0);
        check("R8", ctl_rdata, 16'h8007);
        check("R9", {15'd0, periph_clk_en}, 16'd1);
        step(1'b0, 16'h0, 1'b0, 1'b1);
        check("R5", {15'd0, core_clk_en}, 16'd1);
        check("R5", ctl_rdata, 16'h0007);

        // R6: request while armed cancels
        step(1'b1, 16'h8000, 1'b0, 1'b0);
        check("R6", ctl_rdata, 16'h8000);
        step(1'b0, 16'h0, 1'b0, 1'b1);
        check("R6", ctl_rdata, 16'h0000);
        step(1'b0, 16'h0, 1'b1, 1'b0);
        idle(1);
        check("R6", {15'd0, core_clk_en}, 16'd1);

        // R7: clearing write while armed cancels
        step(1'b1, 16'h8001, 1'b0, 1'b0);
        step(1'b1, 16'h0001, 1'b0, 1'b0);
        check("R7", ctl_rdata, 16'h0001);
        step(1'b0, 16'h0, 1'b1, 1'b0);
        check("R7", {15'd0, core_clk_en}, 16'd1);

        // R7: issue beats a clearing write in the same cycle
        step(1'b1, 16'h8002, 1'b0, 1'b0);
        step(1'b1, 16'h0003, 1'b1, 1'b0);
        check("R7", {15'd0, core_clk_en}, 16'd0);
        check("R7", ctl_rdata, 16'h8003);
        step(1'b0, 16'h0, 1'b0, 1'b1);
        check("R5", {15'd0, core_clk_en}, 16'd1);

        // Random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] wd;
            wd = 16'($urandom);
            step(($urandom % 4) == 0, wd, ($urandom % 3) == 0, ($urandom % 16) == 0);
        end
        idle(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule